// File: doc/BRIEF.md
# GPIO Input Interrupt Controller

This block watches a bank of general-purpose input pins, presents their settled values in a readable input register, and turns pin activity into per-pin interrupt requests. Each pin passes through a two-stage synchronizer. It then passes through an optional per-pin debounce stage, which accepts a new level only after the synchronized value has stayed unchanged for a fixed number of clock cycles. The result is stored in the input register.

Four trigger types are available for each pin: rising edge, falling edge, high level and low level. Each trigger type has its own per-pin enable register. Any enabled trigger that is true in a cycle sets that pin's bit in a sticky status register. Software clears a status bit by writing 1 to it. Software can also set status bits directly through a write-only inject register. Each interrupt output is the status bit gated by a per-pin mask. All registers are reached through a simple word-addressed bus: writes take effect at the clock edge, and reads return data combinationally.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and every irq_o bit is 0.
- R2: With debounce off for a pin, a level applied on pin_i appears in the input register (word 3) after exactly three rising clock edges.
- R3: When bit n of the rise-enable register (word 4) is 1, a 0-to-1 change of input-register bit n sets status bit n (word 0) at the next edge.
- R4: When bit n of the fall-enable register (word 5) is 1, a 1-to-0 change of input-register bit n sets status bit n at the next edge.
- R5: When bit n of the high-enable register (word 6) is 1 and input bit n is 1, status bit n is set. When bit n of the low-enable register (word 7) is 1 and input bit n is 0, status bit n is set.
- R6: Writing word 0 clears each status bit written with 1 and leaves the bits written with 0 unchanged. A trigger active in the same cycle wins over the clear, so a level condition that is still true reads back as set straight after the clear.
- R7: Writing word 2 sets each status bit written with 1 at that edge. Word 2 always reads 0.
- R8: irq_o equals the status register ANDed with the mask register (word 1) in every cycle.
- R9: When bit n of the debounce-enable register (word 8) is 1, input bit n takes a new value only after the synchronized pin has held that value for FILT consecutive cycles. Shorter pulses leave it unchanged.
- R10: irq_o never carries an unknown value after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw input pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register word index |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Read data for the word at addr |
| irq_o | output | NPINS | Per-pin interrupt requests |

## Verification
The patterns cover the following cases:
- Single-pin rising and falling transitions with only one trigger type enabled. These separate edge capture from level capture.
- A held level that is cleared while it is still true. This shows whether a set or a clear wins.
- Inject writes combined with partial masks. These separate the status register from the output gate.
- A short pulse and a long hold on a debounced pin, alongside an undebounced pin. These show where the acceptance threshold lies.
- A long stretch of random pin activity under random enable settings. This is compared against a behavioural model on every cycle.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS = 32,
  parameter int FILT  = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  output logic [NPINS-1:0] irq_o
);
  localparam int CW = $clog2(FILT);
  localparam logic [CW-1:0] CMAX = CW'(FILT - 1);

  logic [NPINS-1:0] s1, s2, din, prev, flag, mask;
  logic [NPINS-1:0] en_rise, en_fall, en_high, en_low, en_filt;
  logic [NPINS-1:0] full, clr, inj, rise, fall, ev;

  assign clr  = (wr_en && addr == AW'(0)) ? wdata : '0;
  assign inj  = (wr_en && addr == AW'(2)) ? wdata : '0;
  assign rise = din & ~prev;
  assign fall = ~din & prev;
  assign ev   = (rise & en_rise) | (fall & en_fall) | (din & en_high) | (~din & en_low);
  assign irq_o = flag & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0; flag <= '0; mask <= '0;
      en_rise <= '0; en_fall <= '0; en_high <= '0; en_low <= '0; en_filt <= '0;
    end else begin
      s1   <= pin_i;
      s2   <= s1;
      prev <= din;
      flag <= (flag & ~clr) | ev | inj;
      if (wr_en) begin
        case (addr)
          AW'(1): mask    <= wdata;
          AW'(4): en_rise <= wdata;
          AW'(5): en_fall <= wdata;
          AW'(6): en_high <= wdata;
          AW'(7): en_low  <= wdata;
          AW'(8): en_filt <= wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic          cand;
    logic [CW-1:0] cnt;
    assign full[i] = (cnt == CMAX);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cand <= 1'b0; cnt <= '0; din[i] <= 1'b0;
      end else begin
        if (s2[i] != cand) begin
          cand <= s2[i];
          cnt  <= '0;
        end else if (!full[i]) begin
          cnt <= cnt + 1'b1;
        end
        if (en_filt[i]) din[i] <= full[i] ? cand : din[i];
        else            din[i] <= s2[i];
      end
    end
  end

  always_comb begin
    case (addr)
      AW'(0):  rdata = flag;
      AW'(1):  rdata = mask;
      AW'(3):  rdata = din;
      AW'(4):  rdata = en_rise;
      AW'(5):  rdata = en_fall;
      AW'(6):  rdata = en_high;
      AW'(7):  rdata = en_low;
      AW'(8):  rdata = en_filt;
      default: rdata = '0;
    endcase
  end

  a_r10_irq_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(irq_o));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flag) & ~$past(clr)) & ~flag) == '0));
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr & ~ev & ~inj) & flag) == '0));
  a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag & $past(rise & en_rise)) == $past(rise & en_rise)));
  a_r7_inject: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2)) |=> ((flag & $past(wdata)) == $past(wdata)));
  a_r9_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((din ^ $past(din)) & $past(en_filt) & ~$past(full)) == '0));
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int N = 32;
  localparam int F = 16;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = '0;
  logic [N-1:0] pin_i = '0, wdata = '0, rdata, irq_o;
  int vecs = 0, errs = 0;
  string phase = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(N), .FILT(F), .AW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  logic [N-1:0] m_s1, m_s2, m_din, m_prev, m_st, m_ie, m_re, m_fe, m_he, m_le, m_fen;
  logic [N-1:0] m_cand;
  int m_cnt [N];

  function automatic logic [N-1:0] m_read(logic [3:0] a);
    case (a)
      0: return m_st;  1: return m_ie;  3: return m_din;
      4: return m_re;  5: return m_fe;  6: return m_he;
      7: return m_le;  8: return m_fen;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_din = '0; m_prev = '0; m_st = '0; m_ie = '0;
      m_re = '0; m_fe = '0; m_he = '0; m_le = '0; m_fen = '0; m_cand = '0;
      for (int i = 0; i < N; i++) m_cnt[i] = 0;
    end else begin
      logic [N-1:0] ev, nd, clr, inj;
      ev = 0; nd = m_din;
      for (int i = 0; i < N; i++) begin
        bit hit;
        hit = (m_re[i] && m_din[i] && !m_prev[i]) || (m_fe[i] && !m_din[i] && m_prev[i])
           || (m_he[i] && m_din[i]) || (m_le[i] && !m_din[i]);
        ev[i] = hit;
        if (!m_fen[i]) nd[i] = m_s2[i];
        else if (m_cnt[i] == F - 1) nd[i] = m_cand[i];
        if (m_s2[i] != m_cand[i]) begin m_cand[i] = m_s2[i]; m_cnt[i] = 0; end
        else if (m_cnt[i] < F - 1) m_cnt[i]++;
      end
      clr = (wr_en && addr == 0) ? wdata : '0;
      inj = (wr_en && addr == 2) ? wdata : '0;
      m_st = (m_st & ~clr) | ev | inj;
      m_prev = m_din; m_din = nd; m_s2 = m_s1; m_s1 = pin_i;
      if (wr_en) case (addr)
        1: m_ie = wdata; 4: m_re = wdata; 5: m_fe = wdata;
        6: m_he = wdata; 7: m_le = wdata; 8: m_fen = wdata;
        default: ;
      endcase
    end
  end

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R8", irq_o, m_st & m_ie);
      chk(phase, rdata, m_read(addr));
    end
  end

  task automatic wr(logic [3:0] a, logic [N-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [N-1:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    errs++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    idle(3); rst_n = 1; idle(1);
    for (int a = 0; a < 9; a++) begin rd(4'(a), v); chk("R1", v, '0); end
    chk("R1", irq_o, '0);

    phase = "R2";
    pin_i = 32'hA5A5_0F00;
    @(posedge clk); @(posedge clk); #1 addr = 3; #0;
    @(posedge clk); #1.5; chk("R2", rdata, 32'hA5A5_0F00);
    pin_i = '0; idle(5);

    phase = "R3";
    wr(1, '1); wr(4, 32'h1);
    pin_i[0] = 1; idle(5);
    rd(0, v); chk("R3", v & 32'h1, 32'h1);
    phase = "R6"; wr(0, 32'h1); rd(0, v); chk("R6", v & 32'h1, 32'h0);

    phase = "R4";
    wr(5, 32'h2); pin_i[1] = 1; idle(5);
    rd(0, v); chk("R4", v & 32'h2, 32'h0);
    pin_i[1] = 0; idle(5);
    rd(0, v); chk("R4", v & 32'h2, 32'h2);

    phase = "R5";
    pin_i[2] = 1; idle(4); wr(6, 32'h4); idle(1);
    rd(0, v); chk("R5", v & 32'h4, 32'h4);
    wr(0, 32'h4); rd(0, v); chk("R6", v & 32'h4, 32'h4);
    wr(7, 32'h8); idle(1);
    rd(0, v); chk("R5", v & 32'h8, 32'h8);
    wr(6, '0); wr(7, '0); wr(0, 32'h2);
    rd(0, v); chk("R6", v & 32'h0000_000E, 32'h0000_000C);
    wr(0, '1); rd(0, v); chk("R6", v, '0);

    phase = "R7";
    wr(2, 32'hF000_0000); rd(0, v); chk("R7", v, 32'hF000_0000);
    rd(2, v); chk("R7", v, '0);
    wr(1, 32'h3000_0000); idle(1);
    chk("R8", irq_o, 32'h3000_0000);
    wr(0, '1); wr(1, '1);

    phase = "R9";
    wr(8, 32'h10);
    pin_i[4] = 1; pin_i[5] = 1; idle(5); pin_i[4] = 0; pin_i[5] = 0; idle(25);
    rd(3, v); chk("R9", v & 32'h30, 32'h00);
    pin_i[4] = 1; idle(10);
    rd(3, v); chk("R9", v & 32'h10, 32'h00);
    idle(15);
    rd(3, v); chk("R9", v & 32'h10, 32'h10);
    pin_i[4] = 0; idle(25);

    phase = "R5";
    for (int k = 0; k < 40; k++) begin
      wr(4'(4 + (k % 5)), $urandom);
      if (k % 7 == 0) wr(1, $urandom);
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        pin_i = pin_i ^ ($urandom & $urandom & $urandom);
        addr = 4'($urandom % 10);
      end
      wr(0, $urandom);
      if (k % 5 == 0) wr(2, $urandom);
    end

    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule